// File: doc/BRIEF.md
# Two-Wire Bus Status Flag Register

This block keeps the event and status flags of a two-wire serial bus controller. A bus engine, which lies outside this block, reports what happens on the wires as single-cycle strobes. These strobes cover a missing acknowledge, an acknowledge seen, a lost arbitration, a misplaced start or stop, a byte shifted out, a byte received, a stop seen on the bus, and a start or stop that the controller generated itself. The engine also drives level inputs for the address phase and for a pending checksum byte. Each flag follows its own set rule and its own clear rule. Several flags are held back or cleared by other events.

Software uses a small register port to reach three registers. Address 0 is the status word. Address 1 is the data register, which software writes with a byte to send and which holds the last byte received. Address 2 is the control word. Three error flags are cleared by writing 0 to their bit. The stop flag is cleared only by a status read followed by a control write. A peripheral enable input clears every flag and holds them clear while it is low. The block also keeps the master/slave mode bit.

Top module: `twi_status_regs`

## Requirements
- R1: After reset, flags_o is all zero and mode_master_o is 0. Status bits 15..11, 5 and 3..0 always read 0.
- R2: A missing-acknowledge strobe sets bit 10, an arbitration-lost strobe sets bit 9 and a misplaced-condition strobe sets bit 8. Each appears in flags_o in the cycle after the strobe.
- R3: A status write with 0 in bit 10, 9 or 8 clears that flag. A 1 in that bit leaves the flag unchanged. If a set strobe and a clearing write fall in the same cycle, the flag ends up set.
- R4: A generated start sets mode_master_o to 1. A lost arbitration or a generated stop returns it to 0, and arbitration loss wins over a start in the same cycle.
- R5: A byte-shifted-out strobe sets bit 7 (transmit empty). It does not set bit 7 when the address phase is high, when a missing-acknowledge strobe arrives in the same cycle, when bit 10 is already set, or when the next byte is the checksum.
- R6: Bit 7 clears on a data-register write, or on a generated start or stop. A set strobe in the same cycle wins.
- R7: A byte-received strobe sets bit 6 (receive not empty) and loads the byte into the data register. It does neither when the address phase is high or when arbitration is lost in the same cycle. Bit 6 clears on a read or write of the data register.
- R8: A bus stop strobe sets bit 4 only if all of the following hold: the mode is slave, control bit 0 (acknowledge enable) is 1, and the most recent acknowledge event was an acknowledge rather than a missing acknowledge.
- R9: Bit 4 clears only when a status read that sees it set is followed by a control write. A control write with no such read leaves it set, and a new stop event between the read and the write cancels the pending clear.
- R10: While the enable input is low, every flag and the mode bit are 0, and strobes set nothing.
- R11: A read returns the status word at address 0, the data byte zero-extended at address 1 and the control word at address 2. reg_rdata_o is 0 when no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Peripheral enable |
| ev_nack_i | input | 1 | Strobe: no acknowledge returned |
| ev_ack_i | input | 1 | Strobe: acknowledge returned |
| ev_arb_lost_i | input | 1 | Strobe: arbitration lost to another master |
| ev_bus_err_i | input | 1 | Strobe: start or stop in an illegal position |
| ev_tx_done_i | input | 1 | Strobe: byte shifted out, data register free |
| ev_rx_byte_i | input | 1 | Strobe: byte received |
| rx_data_i | input | 8 | Received byte, valid with ev_rx_byte_i |
| ev_stop_det_i | input | 1 | Strobe: stop condition seen on the bus |
| ev_start_gen_i | input | 1 | Strobe: start condition generated |
| ev_stop_gen_i | input | 1 | Strobe: stop condition generated |
| addr_phase_i | input | 1 | Level: address phase in progress |
| pec_next_i | input | 1 | Level: next byte to send is the checksum |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 write, 0 read |
| reg_addr_i | input | 2 | 0 status, 1 data, 2 control |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, combinational |
| flags_o | output | 16 | Status word |
| mode_master_o | output | 1 | 1 master, 0 slave |
| data_o | output | 8 | Data register contents |
| ctrl_o | output | 16 | Control word |

## Verification
Each flag, data_o, ctrl_o and mode_master_o is one register stage from its cause, so every result is due in the cycle after the strobe or write. reg_rdata_o is combinational and is due in the same cycle as the request. The bench drives inputs on the falling edge and holds them for exactly one rising edge. It samples registered results at the next falling edge, and it samples read data before the rising edge that ends the request. Read side effects, such as arming the stop clear or clearing receive-not-empty, are checked one cycle after the read.

// File: rtl/twi_stat_pkg.sv
package twi_stat_pkg;
  localparam int REG_W    = 16;
  localparam int BYTE_W   = 8;
  localparam int BIT_AF   = 10;
  localparam int BIT_ARLO = 9;
  localparam int BIT_BERR = 8;
  localparam int BIT_TXE  = 7;
  localparam int BIT_RXNE = 6;
  localparam int BIT_STOP = 4;
  localparam int BIT_ACKEN = 0;
  localparam logic [1:0] ADDR_STAT = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
endpackage

// File: rtl/twi_w0c_flag.sv
module twi_w0c_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic set_i,
  input  logic wr_clr_i,
  output logic q_o
);
  logic q_d;
  always_comb begin
    q_d = q_o;
    if (!en_i)         q_d = 1'b0;
    else if (set_i)    q_d = 1'b1;
    else if (wr_clr_i) q_d = 1'b0;
  end
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= q_d;

  AST_W0C_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && set_i) |=> q_o);  // R3
  AST_W0C_HOLD_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !set_i && !wr_clr_i && q_o) |=> q_o);  // R3
  AST_W0C_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !q_o);  // R10
endmodule

// File: rtl/twi_stop_flag.sv
module twi_stop_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic stop_i,
  input  logic slave_i,
  input  logic ack_en_i,
  input  logic ack_i,
  input  logic nack_i,
  input  logic stat_rd_i,
  input  logic ctrl_wr_i,
  output logic q_o
);
  logic ack_ok_q, armed_q, set_ev;

  // last acknowledge outcome; a stop only counts after a real acknowledge
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     ack_ok_q <= 1'b0;
    else if (!en_i)  ack_ok_q <= 1'b0;
    else if (nack_i) ack_ok_q <= 1'b0;
    else if (ack_i)  ack_ok_q <= 1'b1;

  assign set_ev = stop_i && slave_i && ack_en_i && ack_ok_q && !nack_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                armed_q <= 1'b0;
    else if (!en_i || set_ev)   armed_q <= 1'b0;
    else if (stat_rd_i && q_o)  armed_q <= 1'b1;
    else if (ctrl_wr_i)         armed_q <= 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                    q_o <= 1'b0;
    else if (!en_i)                 q_o <= 1'b0;
    else if (set_ev)                q_o <= 1'b1;
    else if (ctrl_wr_i && armed_q)  q_o <= 1'b0;

  AST_STOP_NO_SET_UNACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!q_o && (!ack_ok_q || !slave_i || !ack_en_i)) |=> !q_o);  // R8
  AST_STOP_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && q_o && !armed_q) |=> q_o);  // R9
endmodule

// File: rtl/twi_data_flags.sv
module twi_data_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tx_done_i,
  input  logic              rx_byte_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              addr_ph_i,
  input  logic              pec_next_i,
  input  logic              nack_i,
  input  logic              af_q_i,
  input  logic              arb_lost_i,
  input  logic              cond_gen_i,
  input  logic              dr_wr_i,
  input  logic              dr_rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              txe_o,
  output logic              rxne_o,
  output logic [DATA_W-1:0] data_o
);
  logic tx_set, rx_set;
  assign tx_set = tx_done_i && !addr_ph_i && !nack_i && !af_q_i && !pec_next_i;
  assign rx_set = rx_byte_i && !addr_ph_i && !arb_lost_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                     txe_o <= 1'b0;
    else if (!en_i)                  txe_o <= 1'b0;
    else if (tx_set)                 txe_o <= 1'b1;
    else if (dr_wr_i || cond_gen_i)  txe_o <= 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                  rxne_o <= 1'b0;
    else if (!en_i)               rxne_o <= 1'b0;
    else if (rx_set)              rxne_o <= 1'b1;
    else if (dr_rd_i || dr_wr_i)  rxne_o <= 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      data_o <= '0;
    else if (rx_set)  data_o <= rx_data_i;
    else if (dr_wr_i) data_o <= wdata_i;

  AST_TXE_NOT_IN_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_ph_i && !txe_o) |=> !txe_o);  // R5
  AST_RXNE_NOT_ON_ARB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((arb_lost_i || addr_ph_i) && !rxne_o) |=> !rxne_o);  // R7
  AST_TXE_CLR_ON_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_gen_i && !tx_done_i) |=> !txe_o);  // R6
endmodule

// File: rtl/twi_status_regs.sv
module twi_status_regs
  import twi_stat_pkg::*;
#(
  parameter int DATA_W = BYTE_W,
  parameter int WORD_W = REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ev_nack_i,
  input  logic              ev_ack_i,
  input  logic              ev_arb_lost_i,
  input  logic              ev_bus_err_i,
  input  logic              ev_tx_done_i,
  input  logic              ev_rx_byte_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              ev_stop_det_i,
  input  logic              ev_start_gen_i,
  input  logic              ev_stop_gen_i,
  input  logic              addr_phase_i,
  input  logic              pec_next_i,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic [WORD_W-1:0] flags_o,
  output logic              mode_master_o,
  output logic [DATA_W-1:0] data_o,
  output logic [WORD_W-1:0] ctrl_o
);
  localparam int NUM_W0C = 3;

  logic stat_wr, stat_rd, dr_wr, dr_rd, ctrl_wr;
  assign stat_wr = reg_req_i &&  reg_we_i && reg_addr_i == ADDR_STAT;
  assign stat_rd = reg_req_i && !reg_we_i && reg_addr_i == ADDR_STAT;
  assign dr_wr   = reg_req_i &&  reg_we_i && reg_addr_i == ADDR_DATA;
  assign dr_rd   = reg_req_i && !reg_we_i && reg_addr_i == ADDR_DATA;
  assign ctrl_wr = reg_req_i &&  reg_we_i && reg_addr_i == ADDR_CTRL;

  // index 0 bus error, 1 arbitration lost, 2 missing acknowledge
  logic [NUM_W0C-1:0] w0c_set, w0c_q;
  assign w0c_set = {ev_nack_i, ev_arb_lost_i, ev_bus_err_i};

  for (genvar i = 0; i < NUM_W0C; i++) begin : g_w0c
    twi_w0c_flag u_flag (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_i),
      .set_i   (w0c_set[i]),
      .wr_clr_i(stat_wr && !reg_wdata_i[BIT_BERR+i]),
      .q_o     (w0c_q[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      ctrl_o <= '0;
    else if (ctrl_wr) ctrl_o <= reg_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                             mode_master_o <= 1'b0;
    else if (!en_i)                          mode_master_o <= 1'b0;
    else if (ev_arb_lost_i || ev_stop_gen_i) mode_master_o <= 1'b0;
    else if (ev_start_gen_i)                 mode_master_o <= 1'b1;

  logic txe_q, rxne_q, stop_q;

  twi_data_flags #(.DATA_W(DATA_W)) u_data (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .tx_done_i (ev_tx_done_i),
    .rx_byte_i (ev_rx_byte_i),
    .rx_data_i (rx_data_i),
    .addr_ph_i (addr_phase_i),
    .pec_next_i(pec_next_i),
    .nack_i    (ev_nack_i),
    .af_q_i    (w0c_q[2]),
    .arb_lost_i(ev_arb_lost_i),
    .cond_gen_i(ev_start_gen_i || ev_stop_gen_i),
    .dr_wr_i   (dr_wr),
    .dr_rd_i   (dr_rd),
    .wdata_i   (reg_wdata_i[DATA_W-1:0]),
    .txe_o     (txe_q),
    .rxne_o    (rxne_q),
    .data_o    (data_o)
  );

  twi_stop_flag u_stop (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .stop_i   (ev_stop_det_i),
    .slave_i  (!mode_master_o),
    .ack_en_i (ctrl_o[BIT_ACKEN]),
    .ack_i    (ev_ack_i),
    .nack_i   (ev_nack_i),
    .stat_rd_i(stat_rd),
    .ctrl_wr_i(ctrl_wr),
    .q_o      (stop_q)
  );

  always_comb begin
    flags_o = '0;
    flags_o[BIT_BERR+NUM_W0C-1:BIT_BERR] = w0c_q;
    flags_o[BIT_TXE]  = txe_q;
    flags_o[BIT_RXNE] = rxne_q;
    flags_o[BIT_STOP] = stop_q;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_req_i && !reg_we_i) begin
      case (reg_addr_i)
        ADDR_STAT: reg_rdata_o = flags_o;
        ADDR_DATA: reg_rdata_o = {{(WORD_W-DATA_W){1'b0}}, data_o};
        ADDR_CTRL: reg_rdata_o = ctrl_o;
        default:   reg_rdata_o = '0;
      endcase
    end
  end

  AST_ARB_TO_SLAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_arb_lost_i |=> !mode_master_o);  // R4
  AST_MODE_OFF_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!mode_master_o && flags_o == '0));  // R10
  AST_RESERVED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_i |=> (flags_o[5] == 1'b0 && flags_o[3:0] == '0));  // R1
endmodule

// File: tb/tb_twi_status_regs.sv
module tb_twi_status_regs;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic en, nack, ack, arb, berr, txd, rxb, stopd, startg, stopg, aph, pec;
  logic [7:0] rxd;
  logic req, we;
  logic [1:0] addr;
  logic [15:0] wdata, rdata, flags, ctrl;
  logic [7:0] data;
  logic mode;

  twi_status_regs dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en),
    .ev_nack_i(nack), .ev_ack_i(ack), .ev_arb_lost_i(arb), .ev_bus_err_i(berr),
    .ev_tx_done_i(txd), .ev_rx_byte_i(rxb), .rx_data_i(rxd),
    .ev_stop_det_i(stopd), .ev_start_gen_i(startg), .ev_stop_gen_i(stopg),
    .addr_phase_i(aph), .pec_next_i(pec),
    .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .flags_o(flags), .mode_master_o(mode),
    .data_o(data), .ctrl_o(ctrl)
  );

  int checks = 0, errors = 0;

  task automatic chk(input string req_s, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req_s, act, exp);
    end
  endtask

  // event bits: 0 nack,1 ack,2 arb,3 berr,4 txd,5 rxb,6 stopd,7 startg,8 stopg
  task automatic set_ev(input logic [8:0] e);
    {stopg, startg, stopd, rxb, txd, berr, arb, ack, nack} = e;
  endtask

  task automatic pulse(input logic [8:0] e);
    @(negedge clk); set_ev(e);
    @(negedge clk); set_ev('0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic t_reset;
    chk("R1 flags", flags, 16'h0);
    chk("R1 mode", mode, 0);
    chk("R11 idle rdata", rdata, 16'h0);
  endtask

  task automatic t_err_flags;
    pulse(9'h001); chk("R2 nack", flags, 16'h0400);
    pulse(9'h004); chk("R2 arb", flags, 16'h0600);
    pulse(9'h008); chk("R2 berr", flags, 16'h0700);
  endtask

  task automatic t_w0c;
    wr(0, 16'hFFFF); chk("R3 write ones", flags, 16'h0700);
    wr(0, 16'hFDFF); chk("R3 clear arlo", flags, 16'h0500);
    @(negedge clk); req = 1; we = 1; addr = 0; wdata = 16'h0000; set_ev(9'h008);
    @(negedge clk); req = 0; we = 0; set_ev('0);
    chk("R3 set wins", flags, 16'h0100);
    wr(0, 16'h0000); chk("R3 clear all", flags, 16'h0000);
  endtask

  task automatic t_mode;
    pulse(9'h080); chk("R4 start master", mode, 1);
    pulse(9'h004); chk("R4 arb slave", mode, 0);
    pulse(9'h084); chk("R4 arb beats start", mode, 0);
    pulse(9'h080); pulse(9'h100); chk("R4 stop slave", mode, 0);
    wr(0, 16'h0000);
  endtask

  task automatic t_txe;
    @(negedge clk); aph = 1; pulse(9'h010); aph = 0;
    chk("R5 addr phase", flags[7], 0);
    pec = 1; pulse(9'h010); pec = 0;
    chk("R5 checksum next", flags[7], 0);
    pulse(9'h011); chk("R5 same-cycle nack", flags[7], 0);
    pulse(9'h010); chk("R5 after nack flag", flags[7], 0);
    wr(0, 16'h0000);
    pulse(9'h010); chk("R5 txe set", flags, 16'h0080);
    wr(1, 16'h005A); chk("R6 data write clears", flags[7], 0);
    chk("R6 data loaded", data, 8'h5A);
    pulse(9'h010); pulse(9'h080); chk("R6 start clears", flags[7], 0);
    pulse(9'h010); pulse(9'h100); chk("R6 stop clears", flags[7], 0);
    pulse(9'h090); chk("R6 set wins", flags[7], 1);
    pulse(9'h100);
    wr(1, 16'h0000);
  endtask

  task automatic t_rxne;
    logic [15:0] v;
    rxd = 8'h3C; aph = 1; pulse(9'h020); aph = 0;
    chk("R7 addr phase", flags[6], 0);
    pulse(9'h024); chk("R7 arb same cycle", flags[6], 0);
    chk("R7 data kept", data, 8'h00);
    wr(0, 16'h0000);
    rxd = 8'hA5; pulse(9'h020); chk("R7 rxne set", flags, 16'h0040);
    rd(1, v); chk("R11 data read", v, 16'h00A5);
    chk("R7 read clears", flags[6], 0);
    pulse(9'h020); wr(1, 16'h0011); chk("R7 write clears", flags[6], 0);
  endtask

  task automatic t_stop;
    logic [15:0] v;
    wr(2, 16'h0001);
    rd(2, v); chk("R11 ctrl read", v, 16'h0001);
    pulse(9'h040); chk("R8 no ack yet", flags[4], 0);
    pulse(9'h002); pulse(9'h001); pulse(9'h040); chk("R8 after nack", flags[4], 0);
    wr(0, 16'h0000);
    pulse(9'h002); pulse(9'h040); chk("R8 stop set", flags, 16'h0010);
    wr(2, 16'h0001); chk("R9 write without read", flags[4], 1);
    rd(0, v); chk("R11 status read", v, 16'h0010);
    pulse(9'h040); wr(2, 16'h0001); chk("R9 re-set cancels arm", flags[4], 1);
    rd(0, v); wr(2, 16'h0001); chk("R9 read then write", flags[4], 0);
    pulse(9'h080); pulse(9'h040); chk("R8 master ignores", flags[4], 0);
    pulse(9'h100);
    wr(2, 16'h0000); pulse(9'h040); chk("R8 ack disabled", flags[4], 0);
  endtask

  task automatic t_disable;
    pulse(9'h009); pulse(9'h080);
    chk("R10 pre", flags, 16'h0500);
    @(negedge clk); en = 0;
    @(negedge clk); chk("R10 flags cleared", flags, 16'h0);
    chk("R10 mode cleared", mode, 0);
    pulse(9'h0AD); chk("R10 strobes ignored", flags, 16'h0);
    chk("R10 mode held", mode, 0);
    @(negedge clk); en = 1;
  endtask

  bit done = 0;
  initial begin
    en = 1; aph = 0; pec = 0; rxd = '0; set_ev('0);
    req = 0; we = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_err_flags();
    t_w0c();
    t_mode();
    t_txe();
    t_rxne();
    t_stop();
    t_disable();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule